// File: doc/BRIEF.md
# SPI Register Access Port with Guarded Write Window

This block is a four-wire SPI target that lets an external host read and write a 128-entry register space of 8-bit words. It drives a simple register-file port (address, write data, write strobe, read strobe, read data) towards the rest of the chip. Every frame opens with a command byte. Its top bit selects write (1) or read (0) and its low seven bits give the start address. Each further byte in the same chip-select-low frame moves to the next address, and the pointer wraps from 0x7F to 0x00. All SPI inputs pass through synchronisers into the system clock. The system clock must run at least four times faster than the serial clock.

Address 0x10 is a lock-control location handled inside the block. It is never forwarded to the register-file port. Writes to 0x11..0x27 pass only while the window is open. A write of 0xBA to 0x10, followed with no other access in between by a write of 0xBE to 0x10, opens the window. Any write to 0x10 of a byte other than 0xBA closes it. A read of 0x10 returns the lock status. Reads of every address are always allowed.

Frame state machine: IDLE goes to CMD when chip select is seen active. CMD goes to WR or RD when the command byte completes, depending on its top bit. Every state returns to IDLE as soon as chip select is seen inactive. Lock state machine: SHUT, SHUT_ARMED, OPEN, OPEN_ARMED. A 0xBA write to 0x10 arms the current side. A 0xBE write while armed goes to OPEN. Any other write to 0x10 goes to SHUT. Any other access drops the armed flag and keeps the open or shut side.

Top module: `spi_guarded_regport`

## Requirements
- R1: While chip select is high, sclk and sdi are ignored, `spi_sdo_en` is 0, and neither register strobe pulses. A frame started afterwards behaves normally.
- R2: sdi is sampled on rising sclk edges, MSB first. Command byte bit 7 = 1 means write and 0 means read; bits 6:0 are the start address.
- R3: In a write frame, each complete data byte gives one single-cycle `rf_we` with address start+n modulo 128, so 0x7F is followed by 0x00. Addresses 0x10 and locked protected addresses are the only exceptions.
- R4: In a read frame, byte n on sdo is the content of address start+n modulo 128, sent MSB first and updated after falling sclk edges. The first read byte directly follows the command byte.
- R5: Each read byte is fetched with one single-cycle `rf_re`, and `rf_rdata` is taken in that same cycle. A read frame of N bytes issues N+1 fetches (one fetch ahead), and fetches of 0x10 issue no strobe. `rf_we` and `rf_re` are never high together.
- R6: Address 0x10 never appears on the register-file port. Reading it returns 0x01 when the window is open and 0x00 when it is shut.
- R7: While shut, writes to 0x11..0x27 are dropped without any strobe, and later bytes of the same frame still reach their addresses.
- R8: A write of 0xBA to 0x10 followed by a write of 0xBE to 0x10 opens the window. After that, protected writes reach the port.
- R9: Any access between the two key writes keeps the window shut. An access is a written data byte or a read fetch, to any address.
- R10: Writing any byte other than 0xBA to 0x10 shuts the window. Writing 0xBA while open keeps it open.
- R11: Raising chip select in the middle of a byte discards the partial byte, with no write. The next frame starts with a fresh command byte.
- R12: After reset the window is shut, `spi_sdo_en` is 0, and no strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial data to the host |
| spi_sdo_en | output | 1 | Output enable for sdo (0 = high impedance) |
| rf_addr | output | 7 | Register-file address |
| rf_wdata | output | 8 | Register-file write data |
| rf_we | output | 1 | Register-file write strobe |
| rf_re | output | 1 | Register-file read strobe |
| rf_rdata | input | 8 | Register-file read data, valid in the `rf_re` cycle |

## Verification
A wrong address pointer shows on the first strobe of the next byte. Either `rf_addr` leaves the start+n sequence, or sdo shifts out the neighbour's content one byte later. A lock state machine stuck in the wrong state shows at the next access to 0x11..0x27 as a missing or extra write strobe. It also shows on the next read of 0x10 as the wrong status byte. A bit counter that survives an aborted frame skews every following command byte, so the very next frame hits a wrong address or direction.

// File: rtl/spi_guard_pkg.sv
package spi_guard_pkg;
    localparam int unsigned AW = 7;
    localparam int unsigned DW = 8;
    localparam int unsigned BW = $clog2(DW);

    localparam logic [AW-1:0] PW_ADDR = 7'h10;
    localparam logic [AW-1:0] PROT_LO = 7'h11;
    localparam logic [AW-1:0] PROT_HI = 7'h27;

    localparam logic [DW-1:0] KEY_FIRST  = 8'hBA;
    localparam logic [DW-1:0] KEY_SECOND = 8'hBE;

    typedef enum logic [1:0] {FR_IDLE, FR_CMD, FR_WR, FR_RD} frame_st_e;
    typedef enum logic [1:0] {LK_SHUT, LK_SHUT_ARMED, LK_OPEN, LK_OPEN_ARMED} lock_st_e;
endpackage

// File: rtl/spi_guard_sync.sv
module spi_guard_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csn,
    input  logic sck,
    input  logic sdi,
    output logic cs_act,
    output logic sck_rise,
    output logic sck_fall,
    output logic sdi_s
);
    localparam int unsigned TOP = STAGES - 1;

    logic [TOP:0] csn_p;
    logic [TOP:0] sck_p;
    logic [TOP:0] sdi_p;
    logic         sck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csn_p <= '1;
            sck_p <= '0;
            sdi_p <= '0;
            sck_d <= 1'b0;
        end else begin
            csn_p <= {csn_p[TOP-1:0], csn};
            sck_p <= {sck_p[TOP-1:0], sck};
            sdi_p <= {sdi_p[TOP-1:0], sdi};
            sck_d <= sck_p[TOP];
        end
    end

    assign cs_act   = !csn_p[TOP];
    assign sck_rise = sck_p[TOP] && !sck_d;
    assign sck_fall = !sck_p[TOP] && sck_d;
    assign sdi_s    = sdi_p[TOP];
endmodule

// File: rtl/spi_guard_lock.sv
module spi_guard_lock
    import spi_guard_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_data,
    output logic          lock_open
);
    lock_st_e st_q, st_d;
    logic     pw_write;
    logic     armed;

    assign pw_write = acc_valid && acc_write && (acc_addr == PW_ADDR);
    assign armed    = (st_q == LK_SHUT_ARMED) || (st_q == LK_OPEN_ARMED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LK_SHUT;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (pw_write) begin
            if (acc_data == KEY_FIRST)
                st_d = lock_open ? LK_OPEN_ARMED : LK_SHUT_ARMED;
            else if (acc_data == KEY_SECOND && armed)
                st_d = LK_OPEN;
            else
                st_d = LK_SHUT;
        end else if (acc_valid) begin
            unique case (st_q)
                LK_SHUT_ARMED: st_d = LK_SHUT;
                LK_OPEN_ARMED: st_d = LK_OPEN;
                LK_SHUT:       st_d = LK_SHUT;
                LK_OPEN:       st_d = LK_OPEN;
                default:       st_d = LK_SHUT;
            endcase
        end
    end

    always_comb begin
        unique case (st_q)
            LK_OPEN, LK_OPEN_ARMED: lock_open = 1'b1;
            default:                lock_open = 1'b0;
        endcase
    end
endmodule

// File: rtl/spi_guard_frame.sv
module spi_guard_frame
    import spi_guard_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          sdi_s,
    input  logic          lock_open,
    input  logic [DW-1:0] rf_rdata,
    output logic [AW-1:0] rf_addr,
    output logic [DW-1:0] rf_wdata,
    output logic          rf_we,
    output logic          rf_re,
    output logic          sdo,
    output logic          sdo_en,
    output logic          acc_valid,
    output logic          acc_write,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] acc_data
);
    frame_st_e     st_q, st_d;
    logic [BW-1:0] bit_q;
    logic [DW-1:0] rx_q, tx_q, rx_nx;
    logic [AW-1:0] ptr_q, ptr_inc, fetch_addr;
    logic          load_q, fetch_pw_q;
    logic          byte_done, fetch_go, wr_go, wr_keep, in_prot;

    assign rx_nx     = {rx_q[DW-2:0], sdi_s};
    assign byte_done = cs_act && sck_rise && (bit_q == BW'(DW - 1));
    assign ptr_inc   = ptr_q + 1'b1;
    assign in_prot   = (ptr_q >= PROT_LO) && (ptr_q <= PROT_HI);
    assign wr_keep   = (ptr_q != PW_ADDR) && !(in_prot && !lock_open);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FR_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (!cs_act) begin
            st_d = FR_IDLE;
        end else begin
            unique case (st_q)
                FR_IDLE: st_d = FR_CMD;
                FR_CMD:  if (byte_done) st_d = rx_nx[DW-1] ? FR_WR : FR_RD;
                FR_WR:   st_d = FR_WR;
                FR_RD:   st_d = FR_RD;
                default: st_d = FR_IDLE;
            endcase
        end
    end

    // byte-level decode
    always_comb begin
        fetch_go   = 1'b0;
        wr_go      = 1'b0;
        fetch_addr = ptr_inc;
        unique case (st_q)
            FR_CMD: begin
                fetch_go   = byte_done && !rx_nx[DW-1];
                fetch_addr = rx_nx[AW-1:0];
            end
            FR_WR:   wr_go    = byte_done;
            FR_RD:   fetch_go = byte_done;
            default: ;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q      <= '0;
            rx_q       <= '0;
            tx_q       <= '0;
            ptr_q      <= '0;
            load_q     <= 1'b0;
            fetch_pw_q <= 1'b0;
            rf_addr    <= '0;
            rf_wdata   <= '0;
            rf_we      <= 1'b0;
            rf_re      <= 1'b0;
            sdo        <= 1'b0;
            sdo_en     <= 1'b0;
            acc_valid  <= 1'b0;
            acc_write  <= 1'b0;
            acc_addr   <= '0;
            acc_data   <= '0;
        end else begin
            rf_we     <= 1'b0;
            rf_re     <= 1'b0;
            acc_valid <= 1'b0;
            load_q    <= 1'b0;
            if (!cs_act) begin
                bit_q  <= '0;
                sdo    <= 1'b0;
                sdo_en <= 1'b0;
            end else begin
                sdo_en <= 1'b1;
                if (sck_rise) begin
                    rx_q  <= rx_nx;
                    bit_q <= bit_q + 1'b1;
                end
                if (st_q == FR_CMD && byte_done)
                    ptr_q <= rx_nx[AW-1:0];
                if (wr_go) begin
                    acc_valid <= 1'b1;
                    acc_write <= 1'b1;
                    acc_addr  <= ptr_q;
                    acc_data  <= rx_nx;
                    ptr_q     <= ptr_inc;
                    if (wr_keep) begin
                        rf_we    <= 1'b1;
                        rf_addr  <= ptr_q;
                        rf_wdata <= rx_nx;
                    end
                end
                if (fetch_go) begin
                    acc_valid  <= 1'b1;
                    acc_write  <= 1'b0;
                    acc_addr   <= fetch_addr;
                    acc_data   <= '0;
                    load_q     <= 1'b1;
                    fetch_pw_q <= (fetch_addr == PW_ADDR);
                    if (st_q == FR_RD) ptr_q <= ptr_inc;
                    if (fetch_addr != PW_ADDR) begin
                        rf_re   <= 1'b1;
                        rf_addr <= fetch_addr;
                    end
                end
                if (sck_fall && st_q == FR_RD) begin
                    sdo  <= tx_q[DW-1];
                    tx_q <= {tx_q[DW-2:0], 1'b0};
                end
                if (load_q)
                    tx_q <= fetch_pw_q ? {{(DW-1){1'b0}}, lock_open} : rf_rdata;
            end
        end
    end
endmodule

// File: rtl/spi_guarded_regport.sv
module spi_guarded_regport
    import spi_guard_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_cs_n,
    input  logic          spi_sclk,
    input  logic          spi_sdi,
    output logic          spi_sdo,
    output logic          spi_sdo_en,
    output logic [AW-1:0] rf_addr,
    output logic [DW-1:0] rf_wdata,
    output logic          rf_we,
    output logic          rf_re,
    input  logic [DW-1:0] rf_rdata
);
    logic          cs_act, sck_rise, sck_fall, sdi_s;
    logic          lock_open;
    logic          acc_valid, acc_write;
    logic [AW-1:0] acc_addr;
    logic [DW-1:0] acc_data;

    spi_guard_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .csn      (spi_cs_n),
        .sck      (spi_sclk),
        .sdi      (spi_sdi),
        .cs_act   (cs_act),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sdi_s    (sdi_s)
    );

    spi_guard_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .sdi_s     (sdi_s),
        .lock_open (lock_open),
        .rf_rdata  (rf_rdata),
        .rf_addr   (rf_addr),
        .rf_wdata  (rf_wdata),
        .rf_we     (rf_we),
        .rf_re     (rf_re),
        .sdo       (spi_sdo),
        .sdo_en    (spi_sdo_en),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_data  (acc_data)
    );

    spi_guard_lock u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_data  (acc_data),
        .lock_open (lock_open)
    );
endmodule

// File: rtl/spi_guarded_regport_chk.sv
module spi_guarded_regport_chk
    import spi_guard_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          spi_cs_n,
    input logic          spi_sdo_en,
    input logic          rf_we,
    input logic          rf_re,
    input logic [AW-1:0] rf_addr,
    input logic          lock_open,
    input logic          acc_valid,
    input logic          acc_write,
    input logic [AW-1:0] acc_addr,
    input logic [DW-1:0] acc_data
);
    // R1: chip select held high for several cycles leaves the port quiet
    a_r1_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n, 1) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3) && $past(spi_cs_n, 4))
        |-> (!rf_we && !rf_re && !spi_sdo_en));

    // R3: write strobes are single-cycle
    a_r3_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);

    // R5: strobes are exclusive
    a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && rf_re));

    // R6: the lock-control location never reaches the register file
    a_r6_pw_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we || rf_re) |-> (rf_addr != PW_ADDR));

    // R7: protected writes only while open
    a_r7_guarded_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_addr >= PROT_LO && rf_addr <= PROT_HI) |-> lock_open);

    // R8: the window opens only after the second key is written
    a_r8_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_open) |-> $past(acc_valid && acc_write && acc_addr == PW_ADDR && acc_data == KEY_SECOND));

    // R10: a non-key write to the lock location shuts the window
    a_r10_shut_on_other: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_addr == PW_ADDR && acc_data != KEY_FIRST && acc_data != KEY_SECOND)
        |=> !lock_open);
endmodule

bind spi_guarded_regport spi_guarded_regport_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_cs_n   (spi_cs_n),
    .spi_sdo_en (spi_sdo_en),
    .rf_we      (rf_we),
    .rf_re      (rf_re),
    .rf_addr    (rf_addr),
    .lock_open  (lock_open),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_addr   (acc_addr),
    .acc_data   (acc_data)
);

// File: tb/tb_spi_guarded_regport.sv
module tb_spi_guarded_regport;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6 * CLK_PERIOD;
    localparam int WATCHDOG   = 150000;

    logic       clk, rst_n;
    logic       spi_cs_n, spi_sclk, spi_sdi;
    logic       spi_sdo, spi_sdo_en;
    logic [6:0] rf_addr;
    logic [7:0] rf_wdata, rf_rdata;
    logic       rf_we, rf_re;

    int n_vec  = 0;
    int n_fail = 0;
    int re_cnt = 0;
    bit done   = 0;

    // register file outside the block
    logic [7:0] rfile [128];
    // reference model
    logic [7:0] m_mem [128];
    bit         m_open  = 0;
    bit         m_armed = 0;
    logic [14:0] exp_q [$];

    spi_guarded_regport dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_cs_n   (spi_cs_n),
        .spi_sclk   (spi_sclk),
        .spi_sdi    (spi_sdi),
        .spi_sdo    (spi_sdo),
        .spi_sdo_en (spi_sdo_en),
        .rf_addr    (rf_addr),
        .rf_wdata   (rf_wdata),
        .rf_we      (rf_we),
        .rf_re      (rf_re),
        .rf_rdata   (rf_rdata)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    assign rf_rdata = rfile[rf_addr];
    always @(posedge clk) if (rf_we) rfile[rf_addr] <= rf_wdata;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // per-clock comparison of the register port against the model queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (rf_re) re_cnt++;
            if ((rf_we || rf_re) && rf_addr == 7'h10)
                chk(0, "R6 lock location on port", rf_addr, 0);
            if (rf_we) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R3/R7 unexpected write", {rf_addr, rf_wdata}, 0);
                end else begin
                    logic [14:0] e;
                    e = exp_q.pop_front();
                    chk({rf_addr, rf_wdata} == e, "R3 write addr/data", {rf_addr, rf_wdata}, e);
                end
            end
        end
    end

    function automatic bit is_prot(input logic [6:0] a);
        return a >= 7'h11 && a <= 7'h27;
    endfunction

    function automatic void mdl_access(input bit wr, input logic [6:0] a, input logic [7:0] d);
        if (wr && a == 7'h10) begin
            if (d == 8'hBA) m_armed = 1;
            else if (d == 8'hBE && m_armed) begin m_open = 1; m_armed = 0; end
            else begin m_open = 0; m_armed = 0; end
        end else begin
            m_armed = 0;
        end
    endfunction

    function automatic logic [7:0] mdl_val(input logic [6:0] a);
        return (a == 7'h10) ? {7'b0, m_open} : m_mem[a];
    endfunction

    task automatic spi_bit(input logic b, output logic r);
        spi_sdi = b;
        #HALF;
        spi_sclk = 1'b1;
        r = spi_sdo;
        #HALF;
        spi_sclk = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            logic r;
            spi_bit(tx[i], r);
            rx[i] = r;
        end
    endtask

    task automatic frame_begin();
        spi_cs_n = 1'b0;
        #HALF;
    endtask

    task automatic frame_end();
        #HALF;
        spi_cs_n = 1'b1;
        #(4 * HALF);
    endtask

    task automatic host_write(input logic [6:0] a, input int n, input logic [63:0] d);
        logic [7:0] rx;
        logic [6:0] cur;
        frame_begin();
        spi_byte({1'b1, a}, rx);
        cur = a;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = d[63 - 8*i -: 8];
            if (cur != 7'h10 && !(is_prot(cur) && !m_open)) begin
                exp_q.push_back({cur, b});
                m_mem[cur] = b;
            end
            mdl_access(1, cur, b);
            spi_byte(b, rx);
            cur = cur + 7'd1;
        end
        frame_end();
    endtask

    task automatic host_read(input logic [6:0] a, input int n, input string tag);
        logic [7:0] rx, exp_cur, exp_nx;
        logic [6:0] cur, nxt;
        int fetches, re0;
        re0 = re_cnt;
        fetches = 0;
        frame_begin();
        spi_byte({1'b0, a}, rx);
        cur = a;
        exp_cur = mdl_val(cur);
        mdl_access(0, cur, 8'h00);
        if (cur != 7'h10) fetches++;
        for (int i = 0; i < n; i++) begin
            spi_byte(8'h00, rx);
            nxt = cur + 7'd1;
            exp_nx = mdl_val(nxt);
            mdl_access(0, nxt, 8'h00);
            if (nxt != 7'h10) fetches++;
            chk(rx == exp_cur, tag, rx, exp_cur);
            cur = nxt;
            exp_cur = exp_nx;
        end
        frame_end();
        chk(re_cnt - re0 == fetches, "R5 read strobe count", re_cnt - re0, fetches);
    endtask

    initial begin
        #(WATCHDOG * CLK_PERIOD);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        logic       rb;
        for (int i = 0; i < 128; i++) begin
            rfile[i] = 8'(i * 3 + 1);
            m_mem[i] = 8'(i * 3 + 1);
        end
        rst_n = 1'b0; spi_cs_n = 1'b1; spi_sclk = 1'b0; spi_sdi = 1'b0;
        #(5 * CLK_PERIOD);
        rst_n = 1'b1;
        #(2 * CLK_PERIOD);

        // R12: reset state
        chk(spi_sdo_en == 0, "R12 sdo_en after reset", spi_sdo_en, 0);
        chk(!rf_we && !rf_re, "R12 strobes after reset", {rf_we, rf_re}, 0);
        host_read(7'h10, 1, "R12 window shut after reset");

        // R2 R3 R4: plain write then read back, several patterns
        host_write(7'h05, 3, {8'hA5, 8'h3C, 8'h81, 40'h0});
        host_read(7'h05, 3, "R4 read back 0x05..0x07");
        host_write(7'h40, 2, {8'h00, 8'hFF, 48'h0});
        host_read(7'h3F, 4, "R2 read span 0x3F..0x42");

        // R3 R4: wrap at the top of the space
        host_write(7'h7E, 4, {8'h11, 8'h22, 8'h33, 8'h44, 32'h0});
        host_read(7'h7F, 3, "R4 read across wrap");

        // R7: locked protected writes dropped, frame continues
        host_write(7'h26, 4, {8'hD1, 8'hD2, 8'hD3, 8'hD4, 32'h0});
        host_read(7'h26, 4, "R7 protected kept, 0x28 written");

        // R8: open the window
        host_write(7'h10, 1, {8'hBA, 56'h0});
        host_write(7'h10, 1, {8'hBE, 56'h0});
        chk(m_open == 1, "R8 model opened", m_open, 1);
        host_read(7'h10, 1, "R8 status reads open");
        host_write(7'h20, 2, {8'h5A, 8'h6B, 48'h0});
        host_read(7'h1F, 3, "R8 protected write landed");

        // R10: BA while open keeps open; other byte shuts
        host_write(7'h10, 1, {8'hBA, 56'h0});
        host_read(7'h10, 1, "R10 BA keeps open");
        host_write(7'h10, 1, {8'h55, 56'h0});
        host_read(7'h10, 1, "R10 other byte shuts");
        host_write(7'h21, 1, {8'hEE, 56'h0});
        host_read(7'h21, 1, "R10 write dropped after shut");

        // R9: intervening access between the keys
        host_write(7'h10, 1, {8'hBA, 56'h0});
        host_read(7'h00, 1, "R9 intervening read");
        host_write(7'h10, 1, {8'hBE, 56'h0});
        host_read(7'h10, 1, "R9 window stays shut");
        host_write(7'h10, 1, {8'hBA, 56'h0});
        host_write(7'h50, 1, {8'h9C, 56'h0});
        host_write(7'h10, 1, {8'hBE, 56'h0});
        host_read(7'h10, 1, "R9 intervening write keeps shut");

        // R11: abort mid-byte
        frame_begin();
        spi_byte({1'b1, 7'h30}, rx);
        exp_q.push_back({7'h30, 8'h77});
        m_mem[7'h30] = 8'h77;
        mdl_access(1, 7'h30, 8'h77);
        spi_byte(8'h77, rx);
        for (int i = 0; i < 4; i++) spi_bit(1'b1, rb);
        spi_cs_n = 1'b1;
        #(4 * HALF);
        host_read(7'h30, 2, "R11 partial byte discarded");

        // R1: activity while deselected is ignored
        begin
            int re0;
            re0 = re_cnt;
            for (int i = 0; i < 16; i++) spi_bit(i[0], rb);
            chk(spi_sdo_en == 0, "R1 sdo_en while deselected", spi_sdo_en, 0);
            chk(re_cnt == re0, "R1 no read strobe", re_cnt - re0, 0);
        end
        frame_begin();
        #(2 * HALF);
        chk(spi_sdo_en == 1, "R1 sdo_en in frame", spi_sdo_en, 1);
        spi_cs_n = 1'b1;
        #(4 * HALF);
        host_read(7'h06, 2, "R1 normal frame after idle toggling");

        chk(exp_q.size() == 0, "R3 all expected writes seen", exp_q.size(), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule